// File: doc/BRIEF.md
# Ping-Pong Corner-Turn Address Generator

This block turns a square matrix of N × N samples (N = 2048 by default) through an external memory so that data leaving a row-wise processing pass reaches the next pass column-wise. It produces only memory commands: write and read addresses, and a bank bit as the address MSB. Write data passes straight through to the memory. The memory controller itself sits outside the block.

Each frame uses one of two placements of the stride, picked per frame:
- **Mode 0:** the writer stores elements at sequential addresses and the reader walks the columns.
- **Mode 1:** the writer scatters elements into column-major positions and the reader walks the memory in order.

Both placements deliver the transposed matrix in the same order. A downstream stage therefore sees an identical arrangement every frame.

The memory holds two banks that alternate roles. While one frame is read out of one bank, the next frame is written into the other. The writer is held off only when its next bank still holds a frame that has not been read.

Top module: `corner_turn_agen`

## Requirements
- R1: After reset, wrReady is 1, rdGrant is 0, and neither memWrEn nor memRdEn is asserted.
- R2: With modeSel = 0 for a frame, the element with input index i = r·N + c is written at low address i. The p-th read of that frame, with p = r'·N + c', uses low address c'·N + r'.
- R3: With modeSel = 1 for a frame, the element with input index i = r·N + c is written at low address c·N + r. The p-th read of that frame uses low address p.
- R4: In either mode, the p-th element read for a frame (p = r'·N + c') equals the input element with index c'·N + r'.
- R5: memWrAddr and memRdAddr carry the bank in their MSB. Frame k since reset is written to bank k mod 2. A write and a read in the same cycle always target different banks.
- R6: While the writer's target bank holds an unread frame, wrReady is 0 and no write command is issued.
- R7: rdGrant is 1 only while the reader's bank holds a complete frame. A read command is issued only when rdReq and rdGrant are both 1.
- R8: The mode is taken from modeSel on the first accepted element of a frame. Later changes of modeSel within that frame have no effect on its addresses or its output order.
- R9: rdLast is 1 together with the read command for the final element (p = N² − 1) of each frame, and at no other time.
- R10: rdReq may drop for any number of cycles inside a frame, and no element is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Stride placement: 0 = strided reads, 1 = strided writes; sampled at frame start |
| wrValid | input | 1 | Writer offers an element |
| wrReady | output | 1 | Element accepted when wrValid and wrReady are both 1 |
| wrData | input | DATA_W | Element data |
| memWrEn | output | 1 | Memory write command |
| memWrAddr | output | 2·DIM_LOG2+1 | Write address; MSB is the bank |
| memWrData | output | DATA_W | Write data |
| rdReq | input | 1 | Reader requests the next element |
| rdGrant | output | 1 | A full frame is available to read |
| memRdEn | output | 1 | Memory read command |
| memRdAddr | output | 2·DIM_LOG2+1 | Read address; MSB is the bank |
| rdLast | output | 1 | Marks the read command of the frame's final element |

## Verification
The bench builds the block with DIM_LOG2 = 2, a 4 × 4 matrix, and a 16-bit data width. At that size six whole frames, each bank fill and drain, and the final-element marker all fall within a few hundred cycles.

The small matrix still gives distinct row and column halves. Each strided address can therefore be told apart from its sequential one. Mixed modes across frames, a mode flip halfway through a frame, and a writer held off by two full banks are all covered in one short run.

// File: rtl/ct_pkg.sv
package ct_pkg;
  // Strobes from the control to the address datapath
  typedef struct packed {
    logic wrFire;     // an element is written this cycle
    logic wrBank;     // bank being filled
    logic wrStrided;  // writer uses column-major placement
    logic rdFire;     // an element is read this cycle
    logic rdBank;     // bank being drained
    logic rdStrided;  // reader walks columns
  } ctStrobes_t;
endpackage

// File: rtl/ct_control.sv
module ct_control
  import ct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       wrValid,
  input  logic       rdReq,
  input  logic       wrAtStart,
  input  logic       wrAtLast,
  input  logic       rdAtLast,
  output logic       wrReady,
  output logic       rdGrant,
  output ctStrobes_t strb
);
  logic [1:0] fullQ;
  logic [1:0] modeQ;
  logic       wrBankQ;
  logic       rdBankQ;
  logic       wrMode;

  always_comb begin
    wrReady        = !fullQ[wrBankQ];
    rdGrant        = fullQ[rdBankQ];
    wrMode         = wrAtStart ? modeSel : modeQ[wrBankQ];
    strb.wrFire    = wrValid && wrReady;
    strb.wrBank    = wrBankQ;
    strb.wrStrided = wrMode;
    strb.rdFire    = rdReq && rdGrant;
    strb.rdBank    = rdBankQ;
    strb.rdStrided = !modeQ[rdBankQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ   <= '0;
      modeQ   <= '0;
      wrBankQ <= 1'b0;
      rdBankQ <= 1'b0;
    end else begin
      if (strb.wrFire && wrAtStart) modeQ[wrBankQ] <= modeSel;
      if (strb.wrFire && wrAtLast) begin
        fullQ[wrBankQ] <= 1'b1;
        wrBankQ        <= !wrBankQ;
      end
      if (strb.rdFire && rdAtLast) begin
        fullQ[rdBankQ] <= 1'b0;
        rdBankQ        <= !rdBankQ;
      end
    end
  end

  // R6: a completed write frame leaves its bank marked full
  a_r6_full_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrFire && wrAtLast) |=> fullQ[$past(wrBankQ)]);

  // R7: a drained bank is released for the writer
  a_r7_free_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdFire && rdAtLast) |=> !fullQ[$past(rdBankQ)]);
endmodule

// File: rtl/ct_addr_path.sv
module ct_addr_path
  import ct_pkg::*;
#(
  parameter int DIM_LOG2 = 11,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = 2 * DIM_LOG2,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAtStart,
  output logic              wrAtLast,
  output logic              rdAtLast,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              rdLast
);
  logic [IDX_W-1:0] wrIdxQ;
  logic [IDX_W-1:0] rdIdxQ;

  // Column-major position of a row-major index: col * N + row
  function automatic logic [IDX_W-1:0] colMajor(input logic [IDX_W-1:0] idx);
    return {idx[DIM_LOG2-1:0], idx[IDX_W-1:DIM_LOG2]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdxQ <= '0;
      rdIdxQ <= '0;
    end else begin
      if (strb.wrFire) wrIdxQ <= wrIdxQ + 1'b1;
      if (strb.rdFire) rdIdxQ <= rdIdxQ + 1'b1;
    end
  end

  always_comb begin
    wrAtStart = (wrIdxQ == '0);
    wrAtLast  = (wrIdxQ == '1);
    rdAtLast  = (rdIdxQ == '1);
    memWrEn   = strb.wrFire;
    memWrAddr = {strb.wrBank, strb.wrStrided ? colMajor(wrIdxQ) : wrIdxQ};
    memWrData = wrData;
    memRdEn   = strb.rdFire;
    memRdAddr = {strb.rdBank, strb.rdStrided ? colMajor(rdIdxQ) : rdIdxQ};
    rdLast    = strb.rdFire && rdAtLast;
  end

  // R2: each accepted write advances the element index by exactly one
  a_r2_wr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFire |=> wrIdxQ == $past(wrIdxQ) + 1'b1);

  // R9: after the frame-last read the reader restarts at element zero
  a_r9_last_wraps: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |=> rdIdxQ == '0);
endmodule

// File: rtl/corner_turn_agen.sv
module corner_turn_agen
  import ct_pkg::*;
#(
  parameter int DIM_LOG2 = 11,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = 2 * DIM_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              rdReq,
  output logic              rdGrant,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              rdLast
);
  ctStrobes_t strb;
  logic       wrAtStart;
  logic       wrAtLast;
  logic       rdAtLast;

  ct_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .wrValid   (wrValid),
    .rdReq     (rdReq),
    .wrAtStart (wrAtStart),
    .wrAtLast  (wrAtLast),
    .rdAtLast  (rdAtLast),
    .wrReady   (wrReady),
    .rdGrant   (rdGrant),
    .strb      (strb)
  );

  ct_addr_path #(.DIM_LOG2(DIM_LOG2), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .wrAtStart (wrAtStart),
    .wrAtLast  (wrAtLast),
    .rdAtLast  (rdAtLast),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memRdEn   (memRdEn),
    .memRdAddr (memRdAddr),
    .rdLast    (rdLast)
  );

  // R5: simultaneous write and read never share a bank
  a_r5_bank_split: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memRdEn) |-> memWrAddr[ADDR_W-1] != memRdAddr[ADDR_W-1]);
endmodule

// File: tb/tb_corner_turn_agen.sv
module tb_corner_turn_agen;
  localparam int DL = 2;
  localparam int N  = 1 << DL;
  localparam int E  = N * N;
  localparam int DW = 16;
  localparam int AW = 2 * DL + 1;
  localparam int FRAMES = 6;

  logic clk = 0;
  logic rstN = 0;
  logic modeSel = 0, wrValid = 0, rdReq = 0;
  logic [DW-1:0] wrData = '0;
  logic wrReady, memWrEn, memRdEn, rdGrant, rdLast;
  logic [AW-1:0] memWrAddr, memRdAddr;
  logic [DW-1:0] memWrData;

  always #2 clk = ~clk;

  corner_turn_agen #(.DIM_LOG2(DL), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .rdReq(rdReq), .rdGrant(rdGrant), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .rdLast(rdLast)
  );

  // Memory model with one cycle of read latency
  logic [DW-1:0] ram [0:(1<<AW)-1];
  logic          rdValQ = 0, rdLastQ = 0;
  logic [DW-1:0] rdDataQ = '0;
  always @(posedge clk) begin
    if (memWrEn) ram[memWrAddr] <= memWrData;
    rdValQ  <= memRdEn;
    rdLastQ <= rdLast;
    rdDataQ <= ram[memRdAddr];
  end

  int nTests = 0, nFail = 0, rdCount = 0, cyc = 0;
  bit rdOn = 0;
  logic [DW:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expWrAddr(input int i, input logic mode);
    return mode ? (i % N) * N + i / N : i;
  endfunction

  // Driver: writes one frame, checks write addresses, pushes expected reads
  task automatic writeFrame(input int f, input logic mode, input bit flip);
    for (int i = 0; i < E; i++) begin
      @(negedge clk);
      wrValid = 1;
      wrData  = DW'(f * 256 + i);
      modeSel = (flip && i >= E / 2) ? ~mode : mode;
      while (!wrReady) @(negedge clk);
      if (i == 0)
        chk(memWrAddr[AW-1] == 1'(f % 2), "R5 bank of frame", int'(memWrAddr[AW-1]), f % 2);
      if (i == 1)
        chk(int'(memWrAddr[AW-2:0]) == expWrAddr(i, mode), mode ? "R3 strided write" : "R2 sequential write",
            int'(memWrAddr[AW-2:0]), expWrAddr(i, mode));
      if (i == E / 2 + 1)
        chk(int'(memWrAddr[AW-2:0]) == expWrAddr(i, mode), "R8 mode held within frame",
            int'(memWrAddr[AW-2:0]), expWrAddr(i, mode));
      @(posedge clk);
    end
    @(negedge clk);
    wrValid = 0;
    for (int p = 0; p < E; p++)
      expQ.push_back({p == E - 1, DW'(f * 256 + (p % N) * N + p / N)});
  endtask

  // Reader stimulus with periodic gaps (R10)
  initial forever begin
    @(negedge clk);
    rdReq = rdOn && (cyc % 3 != 1);
    cyc++;
  end

  // Monitor: compares returned data and last marker against the scoreboard
  always @(negedge clk) begin
    if (rdValQ) begin
      if (expQ.size() == 0) begin
        chk(0, "R7 read with nothing expected", 1, 0);
      end else begin
        logic [DW:0] e;
        e = expQ.pop_front();
        chk(rdDataQ == e[DW-1:0], "R4 R10 transposed element", int'(rdDataQ), int'(e[DW-1:0]));
        chk(rdLastQ == e[DW], "R9 frame-last marker", int'(rdLastQ), int'(e[DW]));
      end
      rdCount++;
    end
  end

  initial begin
    bit timedOut;
    timedOut = 0;
    repeat (3) @(negedge clk);
    chk(wrReady == 1, "R1 wrReady after reset", int'(wrReady), 1);
    chk(rdGrant == 0, "R1 rdGrant after reset", int'(rdGrant), 0);
    chk(!memWrEn && !memRdEn, "R1 no commands in reset", int'(memWrEn | memRdEn), 0);
    rstN = 1;

    writeFrame(0, 1'b0, 0);
    writeFrame(1, 1'b1, 0);
    @(negedge clk);
    wrValid = 1;
    wrData  = 16'hBEEF;
    chk(wrReady == 0, "R6 writer held with both banks full", int'(wrReady), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(memWrEn == 0, "R6 no write while held", int'(memWrEn), 0);
    end
    chk(rdGrant == 1, "R7 grant with full bank", int'(rdGrant), 1);
    wrValid = 0;

    rdOn = 1;
    fork
      begin
        fork
          begin
            writeFrame(2, 1'b0, 1);
            writeFrame(3, 1'b1, 1);
            writeFrame(4, 1'b0, 0);
            writeFrame(5, 1'b1, 0);
            wait (rdCount == FRAMES * E);
          end
          begin
            repeat (20000) @(posedge clk);
            timedOut = 1;
          end
        join_any
        disable fork;
      end
    join
    rdOn = 0;
    if (timedOut) chk(0, "watchdog expired", rdCount, FRAMES * E);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R10 all elements delivered", expQ.size(), 0);
    chk(rdGrant == 0, "R7 no grant after drain", int'(rdGrant), 0);
    chk(wrReady == 1, "R6 writer free after drain", int'(wrReady), 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule